// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block fetches outgoing frames that software has described in a ring of two-word descriptors in shared memory. It reaches that memory through a single word-wide read/write port. A read returns its data one clock after the request. Each descriptor holds a control word and a buffer address word. The control word carries an ownership flag, a chain flag, a wrap flag and a fragment length.

The walker gathers the fragments of a chained frame into a local byte store. It hands the descriptors back to software and raises a one-cycle completion interrupt. It then streams the stored frame out one byte per clock on a valid/last interface.

Frames that span several descriptors are returned to software in a fixed order. The trailing descriptors are zeroed as they are consumed. The first descriptor is released last, so software never sees part of a frame handed back. If a descriptor further down a chain is not owned by the engine, the frame is dropped without being released.

Top module: `tx_ring_walker`

## Requirements
- R1: While `ring_base` is zero or `port_attached` is low, an idle walker issues no memory access.
- R2: A frame starts only when bit 31 (ownership) of the control word at the current pointer is set. An unowned first descriptor is polled again and causes no write, no output byte and no interrupt. `busy` is high from the first control read of an attempt until its last output byte.
- R3: The fragment length is control word bits [LEN_W-1:0] (bits [15:0] by default). Bits 28 down to LEN_W are ignored. A zero-length descriptor adds no byte but is consumed like any other.
- R4: When buffer address bits [31:30] are both one, those two bits are cleared before the buffer is read. Any other address is used unchanged.
- R5: Control bit 30 (chain) set means the next descriptor is fetched and appended to the same frame. Bit 30 clear ends the frame.
- R6: Every descriptor after the first in a frame has its control word overwritten with zero when it is consumed. All these writes come before the first descriptor is released.
- R7: After the whole chain is consumed, the first descriptor's control word is written back with only bit 31 cleared. `irq` pulses for exactly that one cycle.
- R8: If a chained descriptor after the first lacks ownership, the frame is dropped. No byte is emitted, there is no interrupt and the first descriptor is not written. The pointer stays on the unowned descriptor.
- R9: After a descriptor is consumed, the pointer returns to the ring base if control bit 29 (wrap) is set. Otherwise it advances by 8 bytes.
- R10: Frame bytes are output after the release write, one per clock, in buffer address order. The byte at address A is word lane A[1:0] (bits 8*A[1:0]+7 down to 8*A[1:0]). `out_last` marks the final byte. A frame with zero total length produces no output.
- R11: A frame longer than MAX_PKT bytes is truncated to its first MAX_PKT bytes (64 by default). The remaining bytes are still read and the descriptors still consumed.
- R12: A change of `ring_base` seen while idle reloads the descriptor pointer with the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | 32 | Byte address of descriptor 0 of the ring; zero disables the walker |
| port_attached | input | 1 | High when a downstream port can take frames |
| mem_en | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Word-aligned byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| irq | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Walker is processing a descriptor or emitting a frame |

## Verification
The bench targets these corner cases:

- **Chain of three with a zero-length middle link.** A walker that skipped consuming that descriptor would leave it owned and misplace the pointer.
- **Fragment starting on an odd byte.** A wrong byte-lane pick would scramble the output.
- **Tagged and untagged high buffer addresses.** A wrong alias test would read the wrong memory.
- **Wrapped descriptor followed by a chain whose second link is unowned.** A walker that ignored the wrap, or emitted or released the abandoned frame, would show stray writes, bytes or interrupts.
- **Oversize frame.** Missing truncation would overrun the store and misplace `out_last`.
- **Base change with a trap descriptor left owned at the old pointer.** Failing to reload the pointer would transmit the trap.

// File: rtl/txr_pkg.sv
// Shared definitions for the transmit ring walker: control word bit
// positions, the address alias tag and the walker state encoding.
package txr_pkg;
    localparam int OWN_POS   = 31;
    localparam int CHAIN_POS = 30;
    localparam int WRAP_POS  = 29;
    localparam int ALIAS_LO  = 30;
    localparam logic [1:0] ALIAS_TAG = 2'b11;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_RDREQ,
        ST_BYTE,
        ST_STEP,
        ST_NEXT,
        ST_REL,
        ST_EMIT
    } walk_state_t;

    typedef struct packed {
        logic own;
        logic chain;
        logic wrap;
    } desc_flags_t;
endpackage

// File: rtl/txr_desc_decode.sv
// Descriptor field decoder. Pulls the flags and fragment length out of a
// control word and applies the address alias rule to a buffer address word.
// Assumes LEN_W is smaller than WRAP_POS so the flag bits stay clear of it.
module txr_desc_decode
    import txr_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [31:0]      ctrl_word,
    input  logic [31:0]      addr_word,
    output desc_flags_t      flags,
    output logic [LEN_W-1:0] frag_len,
    output logic [31:0]      buf_addr
);
    logic unused_ctrl_bits;

    // Field extraction and alias masking.
    always_comb begin
        flags.own   = ctrl_word[OWN_POS];
        flags.chain = ctrl_word[CHAIN_POS];
        flags.wrap  = ctrl_word[WRAP_POS];
        frag_len    = ctrl_word[LEN_W-1:0];
        if (addr_word[31:ALIAS_LO] == ALIAS_TAG) begin
            buf_addr = {{(32-ALIAS_LO){1'b0}}, addr_word[ALIAS_LO-1:0]};
        end else begin
            buf_addr = addr_word;
        end
    end

    assign unused_ctrl_bits = ^ctrl_word[WRAP_POS-1:LEN_W];
endmodule

// File: rtl/txr_pkt_buf.sv
// Byte store for one frame. Writes are synchronous and reads are
// combinational. The contents are not reset: every byte read out was
// written earlier in the same frame. Assumes DEPTH >= 2.
module txr_pkt_buf #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] store [DEPTH];

    // Capture one fragment byte per write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    assign rd_data = store[rd_idx];
endmodule

// File: rtl/txr_emitter.sv
// Output sequencer. A start pulse with a non-zero count walks the store
// index from zero, presenting one byte per clock and flagging the last one.
// Assumes start is only pulsed while idle and count <= MAX_PKT.
module txr_emitter #(
    parameter int MAX_PKT = 64,
    localparam int IDX_W = $clog2(MAX_PKT),
    localparam int CNT_W = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic [IDX_W-1:0] rd_idx,
    output logic             valid,
    output logic             last
);
    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] len_q;

    // Track the byte position of the frame being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            len_q    <= '0;
        end else if (start && count != '0) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            len_q    <= count;
        end else if (active_q) begin
            if (last) begin
                active_q <= 1'b0;
            end
            idx_q <= idx_q + 1'b1;
        end
    end

    assign valid  = active_q;
    assign last   = active_q && (CNT_W'(idx_q) + CNT_W'(1) == len_q);
    assign rd_idx = idx_q;
endmodule

// File: rtl/tx_ring_walker.sv
// Transmit descriptor ring walker (top). Polls the control word at the
// ring pointer and, when owned, walks the chain, gathering fragment bytes
// into a local store. It zeroes the trailing descriptors, releases the first
// one last with a one-cycle interrupt, then streams the frame.
// Assumes a memory read returns data the cycle after the request and a write
// completes in its request cycle.
module tx_ring_walker
    import txr_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int MAX_PKT    = 64,
    parameter int DESC_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ring_base,
    input  logic        port_attached,
    output logic        mem_en,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        irq,
    output logic        busy
);
    localparam int IDX_W = $clog2(MAX_PKT);
    localparam int CNT_W = $clog2(MAX_PKT + 1);
    localparam logic [31:0] OWN_CLR = ~(32'h1 << OWN_POS);

    walk_state_t       state_q;
    logic [31:0]       ptr_q, base_q, ctrl_q, first_ctrl_q, first_addr_q, baddr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              first_q;

    logic              run_ok;
    logic [31:0]       ctrl_sel;
    desc_flags_t       flags;
    logic [LEN_W-1:0]  frag_len;
    logic [31:0]       buf_addr;
    logic [7:0]        lane_byte;
    logic              buf_wr;
    logic [IDX_W-1:0]  emit_idx;
    logic              emit_start;

    assign run_ok   = (ring_base != '0) && port_attached;
    assign ctrl_sel = (state_q == ST_CTRL) ? mem_rdata : ctrl_q;

    txr_desc_decode #(.LEN_W(LEN_W)) u_decode (
        .ctrl_word (ctrl_sel),
        .addr_word (mem_rdata),
        .flags     (flags),
        .frag_len  (frag_len),
        .buf_addr  (buf_addr)
    );

    // Select the byte lane addressed by the low buffer address bits.
    always_comb begin
        lane_byte = mem_rdata[8*baddr_q[1:0] +: 8];
    end

    assign buf_wr = (state_q == ST_BYTE) && (cnt_q < CNT_W'(MAX_PKT));

    txr_pkt_buf #(.DEPTH(MAX_PKT)) u_buf (
        .clk     (clk),
        .wr_en   (buf_wr),
        .wr_idx  (cnt_q[IDX_W-1:0]),
        .wr_data (lane_byte),
        .rd_idx  (emit_idx),
        .rd_data (out_data)
    );

    assign emit_start = (state_q == ST_REL) && (cnt_q != '0);

    txr_emitter #(.MAX_PKT(MAX_PKT)) u_emit (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (emit_start),
        .count  (cnt_q),
        .rd_idx (emit_idx),
        .valid  (out_valid),
        .last   (out_last)
    );

    // Drive the memory port from the current walker state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr_q;
        mem_wdata = '0;
        case (state_q)
            ST_IDLE:  mem_en = (base_q == ring_base) && run_ok;
            ST_CTRL: begin
                mem_en   = 1'b1;
                mem_addr = ptr_q + 32'd4;
            end
            ST_RDREQ: begin
                mem_en   = 1'b1;
                mem_addr = {baddr_q[31:2], 2'b00};
            end
            ST_STEP: begin
                mem_en = !first_q;
                mem_we = !first_q;
            end
            ST_NEXT:  mem_en = 1'b1;
            ST_REL: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = first_addr_q;
                mem_wdata = first_ctrl_q & OWN_CLR;
            end
            default: ;
        endcase
    end

    // Walker sequencing and descriptor bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            ptr_q        <= '0;
            base_q       <= '0;
            ctrl_q       <= '0;
            first_ctrl_q <= '0;
            first_addr_q <= '0;
            baddr_q      <= '0;
            rem_q        <= '0;
            cnt_q        <= '0;
            first_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (base_q != ring_base) begin
                        base_q <= ring_base;
                        ptr_q  <= ring_base;
                    end else if (run_ok) begin
                        first_q <= 1'b1;
                        cnt_q   <= '0;
                        state_q <= ST_CTRL;
                    end
                end
                ST_CTRL: begin
                    if (!flags.own) begin
                        state_q <= ST_IDLE;
                    end else begin
                        ctrl_q <= mem_rdata;
                        if (first_q) begin
                            first_ctrl_q <= mem_rdata;
                            first_addr_q <= ptr_q;
                        end
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (frag_len == '0) begin
                        state_q <= ST_STEP;
                    end else begin
                        baddr_q <= buf_addr;
                        rem_q   <= frag_len;
                        state_q <= ST_RDREQ;
                    end
                end
                ST_RDREQ: state_q <= ST_BYTE;
                ST_BYTE: begin
                    if (cnt_q < CNT_W'(MAX_PKT)) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    baddr_q <= baddr_q + 32'd1;
                    rem_q   <= rem_q - 1'b1;
                    state_q <= (rem_q == LEN_W'(1)) ? ST_STEP : ST_RDREQ;
                end
                ST_STEP: begin
                    ptr_q   <= flags.wrap ? base_q : ptr_q + 32'(DESC_BYTES);
                    first_q <= 1'b0;
                    state_q <= flags.chain ? ST_NEXT : ST_REL;
                end
                ST_NEXT:  state_q <= ST_CTRL;
                ST_REL:   state_q <= (cnt_q != '0) ? ST_EMIT : ST_IDLE;
                ST_EMIT: begin
                    if (out_last) begin
                        state_q <= ST_IDLE;
                    end
                end
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign irq  = (state_q == ST_REL);
    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/txr_checker.sv
// Protocol checker for the ring walker, attached to every instance of the
// top module through the bind below. Observes ports only.
module txr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ring_base,
    input logic        port_attached,
    input logic        mem_en,
    input logic        mem_we,
    input logic [31:0] mem_wdata,
    input logic        out_valid,
    input logic        out_last,
    input logic        irq,
    input logic        busy
);
    // R1: a disabled, idle walker leaves memory alone.
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (ring_base == '0 || !port_attached)) |-> !mem_en);

    // R7: the interrupt lasts one cycle.
    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: the interrupt coincides with a write that clears ownership.
    assert_release_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mem_en && mem_we && !mem_wdata[31]));

    // R6: every other write hands a descriptor back as zero.
    assert_zero_handback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !irq) |-> (mem_wdata == '0));

    // R10: last only with valid.
    assert_last_has_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R10: bytes flow only after fetching is over, within a busy period.
    assert_emit_after_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!mem_en && busy));
endmodule

bind tx_ring_walker txr_checker u_txr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .ring_base     (ring_base),
    .port_attached (port_attached),
    .mem_en        (mem_en),
    .mem_we        (mem_we),
    .mem_wdata     (mem_wdata),
    .out_valid     (out_valid),
    .out_last      (out_last),
    .irq           (irq),
    .busy          (busy)
);

// File: tb/tx_ring_walker_tb_top.sv
`timescale 1ns/1ps
module tx_ring_walker_tb_top;
    localparam int MAXB = 64;
    localparam logic [31:0] OWN   = 32'h8000_0000;
    localparam logic [31:0] CHAIN = 32'h4000_0000;
    localparam logic [31:0] WRAP  = 32'h2000_0000;
    localparam logic [31:0] JUNK  = 32'h0123_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_base = 32'h100;
    logic        port_attached = 1'b0;
    logic        mem_en, mem_we, out_valid, out_last, irq, busy;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  out_data;

    logic [31:0] bmem [1024];
    logic [63:0] exp_w [$];
    logic [8:0]  exp_b [$];
    logic [31:0] mptr;
    int checks = 0, errors = 0, cyc = 0;
    int irq_exp = 0, irq_seen = 0, men_cnt = 0, out_cnt = 0;

    always #2 clk = ~clk;

    tx_ring_walker #(.MAX_PKT(MAXB)) dut_i (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .port_attached(port_attached),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .irq(irq), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a[31:12] == '0) return bmem[a[11:2]];
        return {a[31:2], 2'b00} ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        logic [31:0] w;
        w = mem_word(a);
        return w[8*a[1:0] +: 8];
    endfunction

    // Memory model: read data one cycle after the request.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                if (mem_addr[31:12] == '0) bmem[mem_addr[11:2]] = mem_wdata;
            end else begin
                mem_rdata <= mem_word(mem_addr);
            end
        end
    end

    // Per-clock comparison of the ports against the reference queues.
    always @(negedge clk) begin : mon
        logic [63:0] e;
        logic [8:0]  eb;
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (rst_n) begin
            if (mem_en) men_cnt++;
            if (mem_en && mem_we) begin
                if (exp_w.size() == 0) begin
                    chk(1'b0, "R6", "unexpected write", mem_addr, 32'h0);
                end else begin
                    e = exp_w.pop_front();
                    chk(mem_addr == e[63:32], (e[31:0] == 0) ? "R6" : "R7", "write address", mem_addr, e[63:32]);
                    chk(mem_wdata == e[31:0], (e[31:0] == 0) ? "R6" : "R7", "write data", mem_wdata, e[31:0]);
                end
            end
            if (out_valid) begin
                out_cnt++;
                if (exp_b.size() == 0) begin
                    chk(1'b0, "R10", "unexpected byte", {24'h0, out_data}, 32'h0);
                end else begin
                    eb = exp_b.pop_front();
                    chk(out_data == eb[7:0], "R10", "byte value", {24'h0, out_data}, {24'h0, eb[7:0]});
                    chk(out_last == eb[8], "R10", "last flag", {31'h0, out_last}, {31'h0, eb[8]});
                end
            end
            if (irq) irq_seen++;
        end
    end

    // Reference walk over the descriptors starting at mptr.
    task automatic predict();
        logic [31:0] a, c, ba, fa, fc, nxt;
        logic [8:0]  tmp [$];
        bit first;
        a = mptr;
        first = 1;
        forever begin
            c = mem_word(a);
            if (!c[31]) begin
                if (!first) mptr = a;
                return;
            end
            if (first) begin
                fa = a;
                fc = c;
            end
            ba = mem_word(a + 4);
            if (ba[31:30] == 2'b11) ba = {2'b00, ba[29:0]};
            for (int k = 0; k < int'(c[15:0]); k++) begin
                if (tmp.size() < MAXB) tmp.push_back({1'b0, byte_at(ba + 32'(k))});
            end
            if (!first) exp_w.push_back({a, 32'h0});
            nxt = c[29] ? ring_base : a + 32'd8;
            first = 0;
            if (!c[30]) begin
                exp_w.push_back({fa, fc & ~OWN});
                irq_exp++;
                mptr = nxt;
                if (tmp.size() > 0) tmp[tmp.size()-1][8] = 1'b1;
                foreach (tmp[i]) exp_b.push_back(tmp[i]);
                return;
            end
            a = nxt;
        end
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] ctrl, input logic [31:0] addr);
        bmem[at[11:2]]     = ctrl;
        bmem[at[11:2] + 1] = addr;
    endtask

    task automatic run_frame(input string tag, input int exp_bytes);
        int n;
        predict();
        out_cnt = 0;
        @(negedge clk);
        port_attached = 1'b1;
        n = 0;
        while (!(exp_w.size() == 0 && exp_b.size() == 0 && !busy) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (20) @(negedge clk);
        port_attached = 1'b0;
        while (busy) @(negedge clk);
        chk(exp_w.size() == 0, tag, "pending writes", exp_w.size(), 0);
        chk(exp_b.size() == 0, tag, "pending bytes", exp_b.size(), 0);
        chk(irq_seen == irq_exp, tag, "interrupt count", irq_seen, irq_exp);
        chk(out_cnt == exp_bytes, tag, "bytes emitted", out_cnt, exp_bytes);
        exp_w.delete();
        exp_b.delete();
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            bmem[i] = (i < 256) ? 32'h0 : ({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)} ^ 32'h1122_3344);
        end
        mptr = 32'h100;
        repeat (3) @(negedge clk);
        chk(!busy && !out_valid && !irq && !mem_en, "R2", "reset state", {busy, out_valid, irq, mem_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !out_valid && !irq, "R2", "state after reset", {busy, out_valid, irq}, 0);

        // R1: no access while detached, then while the base is zero
        men_cnt = 0;
        repeat (20) @(negedge clk);
        chk(men_cnt == 0, "R1", "accesses while detached", men_cnt, 0);
        ring_base = 32'h0;
        port_attached = 1'b1;
        repeat (20) @(negedge clk);
        chk(men_cnt == 0, "R1", "accesses with zero base", men_cnt, 0);
        port_attached = 1'b0;
        ring_base = 32'h100;
        repeat (3) @(negedge clk);

        // R2: unowned descriptor is only polled
        men_cnt = 0;
        run_frame("R2 unowned poll", 0);
        chk(men_cnt > 0, "R2", "polling reads seen", men_cnt, 1);

        // R2 and R7: single owned descriptor, odd start address
        put_desc(32'h100, OWN | JUNK | 32'd5, 32'h203);
        run_frame("R7 single frame", 5);

        // R3, R5, R6: chain of three with a zero-length middle link
        put_desc(32'h108, OWN | CHAIN | 32'd3, 32'h400);
        put_desc(32'h110, OWN | CHAIN | JUNK, 32'h999);
        put_desc(32'h118, OWN | 32'd4, 32'h411);
        run_frame("R5 chain R3 zero link", 7);

        // R4: tagged address aliased, untagged high address kept
        put_desc(32'h120, OWN | CHAIN | 32'd4, 32'hC000_0302);
        put_desc(32'h128, OWN | 32'd3, 32'h8000_0041);
        run_frame("R4 alias", 7);

        // R10: zero total length gives release and interrupt but no bytes
        put_desc(32'h130, OWN | 32'd0, 32'h0);
        run_frame("R10 empty frame", 0);

        // R9: wrap back to the base
        put_desc(32'h138, OWN | WRAP | 32'd2, 32'h500);
        run_frame("R9 wrap", 2);

        // R8: second link unowned, frame dropped
        put_desc(32'h100, OWN | CHAIN | 32'd2, 32'h600);
        put_desc(32'h108, CHAIN | 32'd3, 32'h700);
        run_frame("R8 abandon", 0);
        chk(bmem[32'h100 >> 2] == (OWN | CHAIN | 32'd2), "R8", "first left owned", bmem[32'h100 >> 2], OWN | CHAIN | 32'd2);
        put_desc(32'h108, OWN | 32'd3, 32'h700);
        run_frame("R8 resume at unowned R9", 3);

        // R11: oversize frame truncated
        put_desc(32'h110, OWN | 32'd70, 32'h800);
        run_frame("R11 truncation", MAXB);

        // R12: base change reloads pointer; trap left at old pointer
        put_desc(32'h118, OWN | 32'd1, 32'hA00);
        ring_base = 32'h180;
        repeat (3) @(negedge clk);
        mptr = 32'h180;
        put_desc(32'h180, OWN | 32'd2, 32'h900);
        run_frame("R12 base reload", 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule